// File: doc/BRIEF.md
# Multiplexed Flash Bus Cycle Host Engine

This block is the host side of a 4-bit multiplexed flash bus. It turns one command into one complete single memory read or write cycle. The bus can be the firmware-hub flavour, plain LPC, or LPC with an ISA-style start. For each bus clock the engine either drives one nibble on the shared data lines, with a separate enable, or samples one nibble from the peripheral. The active-low frame strobe marks the first start nibble.

A command carries the bus flavour, the direction, a 32-bit address, the byte count as its base-2 logarithm, and the write data. The engine drives the framing, the address and size nibbles, and the write data. It then hands the lines over and waits through the peripheral's sync wait codes. It captures read data and checks the closing turnaround. It ends with a one-cycle done pulse and an error flag. A programmable limit on long wait codes stops a stalled peripheral from hanging the host. Clock generation, flash command sequences and reset or write-protect pins are handled elsewhere.

Top module: `lpc_host_engine`

## Requirements
- R1: The bus-flavour code is 0 for firmware hub, 1 for plain LPC and 2 for ISA-style LPC; code 3 acts as plain LPC. The first host nibble is the start nibble, and the frame strobe is low for that one clock only. The start nibble is 0xD for a firmware-hub read, 0xE for a firmware-hub write, 0x4 for a plain LPC read and 0x7 for a plain LPC write.
- R2: In ISA-style mode the host sends 0x0 with the frame strobe low. It then sends a cycle-type nibble with the strobe high: 0x4 for a read, 0x6 for a write.
- R3: After the start field the host sends one 0x0 device-select nibble. It then sends the address, most significant nibble first. The address is 7 nibbles (bits 27..0) on firmware hub and 8 nibbles (bits 31..0) on either LPC flavour.
- R4: The next nibble is the size field, equal to the log2 of the byte count. A requested size above MAX_LOG2 is clamped to MAX_LOG2, both on the bus and in the number of bytes moved.
- R5: On a write, each byte follows the size field, byte 0 first. A byte is sent low nibble then high nibble, byte j taken from write-data bits 8j+7..8j. After the last host field the host drives 0xF for exactly one clock, then drops the drive enable.
- R6: The clock after the host releases the lines is ignored. Sync sampling starts on the clock after it. Sync 0x0 means ready; 0x5 (short wait) and 0x6 (long wait) both keep the engine sampling sync.
- R7: A sync value other than 0x0, 0x5 or 0x6 ends the cycle at once, with done and error asserted together on the next clock.
- R8: On a read, bytes arrive after the ready sync, low nibble then high nibble. They are presented on read data with byte j in bits 8j+7..8j, with unused upper bytes zero. A read clears read data when it starts. A write leaves read data unchanged.
- R9: After the peripheral's part there are two turnaround clocks. If the first does not read 0xF, error is raised with done. Done rises on the clock after the second turnaround clock.
- R10: Busy is high from the clock after a command is taken until done. A command presented while busy is ignored: no extra nibbles and no extra done.
- R11: If a cycle sees more long-wait codes than the long-wait limit input allows, the cycle aborts with done and error. A limit of L tolerates L long waits.
- R12: Done is a single-cycle pulse, and error is high only in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_bus | input | 2 | Bus flavour: 0 firmware hub, 1 LPC, 2 ISA-style LPC |
| cmd_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_addr | input | 32 | Target address |
| cmd_size_log2 | input | 3 | log2 of the byte count |
| cmd_wdata | input | DATA_W | Write bytes, byte 0 in the low bits |
| long_wait_limit | input | LIMIT_W | Long waits tolerated per cycle |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven to the bus |
| lad_oe | output | 1 | Host drive enable for the data lines |
| lframe_n | output | 1 | Active-low frame strobe |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| error | output | 1 | Cycle failed, valid with done |
| rdata | output | DATA_W | Captured read bytes |

## Verification
The bench checks each bus flavour on every host-driven nibble, so a swapped start code, a missing or extra address nibble, or an address sent in the wrong order shows up as a stream mismatch. It drives a junk value in the released clock after turnaround. A design that sampled sync one clock early would abort on that value. It runs short and long wait codes, an invalid sync code, and long waits just inside and just past the limit. A wrong wait decoder would then hang, finish early or miss the abort. It also checks a bad closing turnaround, an oversized size request, and a command issued during a busy cycle. A design that skipped the check, failed to clamp, or re-armed while busy would report the wrong error, move the wrong number of bytes, or emit a second cycle.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

   typedef enum logic [1:0] {
      BUS_FWH     = 2'd0,
      BUS_LPC     = 2'd1,
      BUS_LPC_ISA = 2'd2
   } bus_kind_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HOST  = 3'd1,
      ST_REL   = 3'd2,
      ST_SYNC  = 3'd3,
      ST_RDATA = 3'd4,
      ST_PTA   = 3'd5,
      ST_PTB   = 3'd6
   } eng_state_t;

   localparam logic [3:0] SYNC_READY = 4'h0;
   localparam logic [3:0] SYNC_SHORT = 4'h5;
   localparam logic [3:0] SYNC_LONG  = 4'h6;
   localparam logic [3:0] NIB_TURN   = 4'hF;

endpackage

// File: rtl/lpc_field_gen.sv
module lpc_field_gen
   import lpc_host_pkg::*;
#(
   parameter int MAX_LOG2 = 2,
   parameter int DATA_W   = 8 << MAX_LOG2,
   parameter int IDX_W    = 5,
   parameter int CW       = 4
)(
   input  bus_kind_t          bus,
   input  logic               write,
   input  logic [31:0]        addr,
   input  logic [2:0]         size,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [IDX_W-1:0]   idx,
   output logic [3:0]         nib,
   output logic               last,
   output logic [CW-1:0]      dnib
);

   int n_start, n_addr, n_data, i, data_base, turn_idx, sh;

   always_comb begin
      n_start   = (bus == BUS_LPC_ISA) ? 2 : 1;
      n_addr    = (bus == BUS_FWH) ? 7 : 8;
      n_data    = 2 << int'(size);
      data_base = n_start + n_addr + 2;
      turn_idx  = data_base + (write ? n_data : 0);
      i         = int'(idx);
      sh        = 0;
      nib       = NIB_TURN;
      if (i == 0) begin
         unique case (bus)
            BUS_FWH:     nib = write ? 4'hE : 4'hD;
            BUS_LPC_ISA: nib = 4'h0;
            default:     nib = write ? 4'h7 : 4'h4;
         endcase
      end else if (i < n_start) begin
         nib = write ? 4'h6 : 4'h4;
      end else if (i == n_start) begin
         nib = 4'h0;
      end else if (i <= n_start + n_addr) begin
         sh  = n_addr - (i - n_start);
         nib = 4'(addr >> (4 * sh));
      end else if (i == n_start + n_addr + 1) begin
         nib = {1'b0, size};
      end else if (i < turn_idx) begin
         nib = 4'(wdata >> (4 * (i - data_base)));
      end
      last = (i == turn_idx);
      dnib = CW'(n_data);
   end

endmodule

// File: rtl/lpc_wait_guard.sv
module lpc_wait_guard #(
   parameter int LIMIT_W = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               long_seen,
   input  logic [LIMIT_W-1:0] limit,
   output logic               expired
);

   logic [LIMIT_W-1:0] waits_q;

   assign expired = long_seen && (waits_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         waits_q <= '0;
      else if (long_seen && !expired)
         waits_q <= waits_q + 1'b1;
   end

endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
   import lpc_host_pkg::*;
#(
   parameter int MAX_LOG2 = 2,
   parameter int LIMIT_W  = 16,
   localparam int DATA_W  = 8 << MAX_LOG2,
   localparam int NIB_MAX = 2 << MAX_LOG2,
   localparam int IDX_W   = $clog2(NIB_MAX + 14),
   localparam int CW      = $clog2(NIB_MAX) + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_bus,
   input  logic               cmd_write,
   input  logic [31:0]        cmd_addr,
   input  logic [2:0]         cmd_size_log2,
   input  logic [DATA_W-1:0]  cmd_wdata,
   input  logic [LIMIT_W-1:0] long_wait_limit,
   input  logic [3:0]         lad_in,
   output logic [3:0]         lad_out,
   output logic               lad_oe,
   output logic               lframe_n,
   output logic               busy,
   output logic               done,
   output logic               error,
   output logic [DATA_W-1:0]  rdata
);

   generate
      if (MAX_LOG2 < 0 || MAX_LOG2 > 7) begin : g_bad_size
         $error("MAX_LOG2 must lie in 0..7 to fit the size nibble");
      end
      if (LIMIT_W < 1) begin : g_bad_limit
         $error("LIMIT_W must be at least 1");
      end
   endgenerate

   eng_state_t          state_q;
   bus_kind_t           bus_q;
   logic                wr_q;
   logic [31:0]         addr_q;
   logic [2:0]          size_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [IDX_W-1:0]    idx_q;
   logic [CW-1:0]       cnt_q;
   logic                err_q;

   logic [3:0]          host_nib;
   logic                host_last;
   logic [CW-1:0]       data_nibs;
   logic                long_seen;
   logic                wait_expired;

   lpc_field_gen #(
      .MAX_LOG2 (MAX_LOG2),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .CW       (CW)
   ) u_fields (
      .bus   (bus_q),
      .write (wr_q),
      .addr  (addr_q),
      .size  (size_q),
      .wdata (wdata_q),
      .idx   (idx_q),
      .nib   (host_nib),
      .last  (host_last),
      .dnib  (data_nibs)
   );

   assign long_seen = (state_q == ST_SYNC) && (lad_in == SYNC_LONG);

   lpc_wait_guard #(.LIMIT_W(LIMIT_W)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == ST_IDLE),
      .long_seen (long_seen),
      .limit     (long_wait_limit),
      .expired   (wait_expired)
   );

   assign lad_oe   = (state_q == ST_HOST);
   assign lad_out  = lad_oe ? host_nib : NIB_TURN;
   assign lframe_n = !(lad_oe && idx_q == '0);
   assign busy     = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bus_q   <= BUS_LPC;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         wdata_q <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         err_q   <= 1'b0;
         done    <= 1'b0;
         error   <= 1'b0;
         rdata   <= '0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  bus_q   <= (cmd_bus == 2'd0) ? BUS_FWH :
                             (cmd_bus == 2'd2) ? BUS_LPC_ISA : BUS_LPC;
                  wr_q    <= cmd_write;
                  addr_q  <= cmd_addr;
                  size_q  <= (int'(cmd_size_log2) > MAX_LOG2) ? 3'(MAX_LOG2)
                                                              : cmd_size_log2;
                  wdata_q <= cmd_wdata;
                  idx_q   <= '0;
                  cnt_q   <= '0;
                  err_q   <= 1'b0;
                  if (!cmd_write) rdata <= '0;
                  state_q <= ST_HOST;
               end
            end
            ST_HOST: begin
               if (host_last) state_q <= ST_REL;
               else           idx_q   <= idx_q + 1'b1;
            end
            ST_REL: state_q <= ST_SYNC;
            ST_SYNC: begin
               if (lad_in == SYNC_READY) begin
                  state_q <= wr_q ? ST_PTA : ST_RDATA;
               end else if (lad_in == SYNC_SHORT || (long_seen && !wait_expired)) begin
                  state_q <= ST_SYNC;
               end else begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
                  error   <= 1'b1;
               end
            end
            ST_RDATA: begin
               rdata[4*int'(cnt_q) +: 4] <= lad_in;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == data_nibs - 1'b1) state_q <= ST_PTA;
            end
            ST_PTA: begin
               if (lad_in != NIB_TURN) err_q <= 1'b1;
               state_q <= ST_PTB;
            end
            ST_PTB: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
               error   <= err_q;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lpc_host_checker.sv
module lpc_host_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       busy,
   input logic       done,
   input logic       error,
   input logic       lad_oe,
   input logic       lframe_n,
   input logic [3:0] lad_out
);

   assert_frame_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lframe_n |-> lad_oe);

   assert_frame_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lframe_n |=> lframe_n);

   assert_release_after_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lad_oe) |-> $past(lad_out) == 4'hF);

   assert_start_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !lad_oe);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_error_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

endmodule

bind lpc_host_engine lpc_host_checker u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .done      (done),
   .error     (error),
   .lad_oe    (lad_oe),
   .lframe_n  (lframe_n),
   .lad_out   (lad_out)
);

// File: tb/lpc_host_engine_test.sv
`timescale 1ns/1ps
module lpc_host_engine_test;

   localparam int DW = 32;

   typedef struct {
      logic [4:0] val;
      string      req;
   } nib_item_t;

   typedef struct {
      logic          err;
      logic [DW-1:0] rd;
      string         req;
   } res_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_bus = 2'd0;
   logic          cmd_write = 1'b0;
   logic [31:0]   cmd_addr = '0;
   logic [2:0]    cmd_size_log2 = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [15:0]   long_wait_limit = 16'd2;
   logic [3:0]    lad_in = 4'hF;
   logic [3:0]    lad_out;
   logic          lad_oe;
   logic          lframe_n;
   logic          busy;
   logic          done;
   logic          error;
   logic [DW-1:0] rdata;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit finished = 1'b0;
   logic [DW-1:0] rd_model = '0;

   nib_item_t nibq[$];
   res_item_t resq[$];

   always #2 clk = ~clk;

   lpc_host_engine uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid       (cmd_valid),
      .cmd_bus         (cmd_bus),
      .cmd_write       (cmd_write),
      .cmd_addr        (cmd_addr),
      .cmd_size_log2   (cmd_size_log2),
      .cmd_wdata       (cmd_wdata),
      .long_wait_limit (long_wait_limit),
      .lad_in          (lad_in),
      .lad_out         (lad_out),
      .lad_oe          (lad_oe),
      .lframe_n        (lframe_n),
      .busy            (busy),
      .done            (done),
      .error           (error),
      .rdata           (rdata)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_nib(input logic lf, input logic [3:0] n, input string req);
      nib_item_t it;
      it.val = {lf, n};
      it.req = req;
      nibq.push_back(it);
   endtask

   // Monitor: compares every driven nibble and every done against the queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (lad_oe) begin
            if (nibq.size() == 0) begin
               check(1'b0, "R5 unexpected host nibble", {59'd0, lframe_n, lad_out}, 64'd0);
            end else begin
               nib_item_t e;
               e = nibq.pop_front();
               check({lframe_n, lad_out} == e.val, e.req, {59'd0, lframe_n, lad_out}, {59'd0, e.val});
            end
         end
         if (done) begin
            if (resq.size() == 0) begin
               check(1'b0, "R10 unexpected done", 64'd1, 64'd0);
            end else begin
               res_item_t r;
               r = resq.pop_front();
               check(error == r.err, {r.req, " error"}, {63'd0, error}, {63'd0, r.err});
               check(rdata == r.rd, {r.req, " rdata"}, {32'd0, rdata}, {32'd0, r.rd});
            end
         end
      end
   end

   task automatic run_cycle(input int bus, input bit wr, input logic [31:0] addr, input int sz,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                            input logic [31:0] syncs, input int nsync, input bit abort_exp,
                            input logic [3:0] tar0, input bit inject, input string req);
      int esz, nb, na;
      res_item_t r;
      esz = (sz > 2) ? 2 : sz;
      nb  = 1 << esz;
      na  = (bus == 0) ? 7 : 8;
      // expected host stream
      if (bus == 0)      push_nib(1'b0, wr ? 4'hE : 4'hD, {req, " R1 start"});
      else if (bus == 2) begin
         push_nib(1'b0, 4'h0, {req, " R2 start"});
         push_nib(1'b1, wr ? 4'h6 : 4'h4, {req, " R2 type"});
      end else           push_nib(1'b0, wr ? 4'h7 : 4'h4, {req, " R1 start"});
      push_nib(1'b1, 4'h0, {req, " R3 idsel"});
      for (int k = na - 1; k >= 0; k--) push_nib(1'b1, addr[4*k +: 4], {req, " R3 addr"});
      push_nib(1'b1, 4'(esz), {req, " R4 size"});
      if (wr) for (int j = 0; j < 2 * nb; j++) push_nib(1'b1, wd[4*j +: 4], {req, " R5 wdata"});
      push_nib(1'b1, 4'hF, {req, " R5 turn"});
      // expected result
      r.err = abort_exp || (tar0 != 4'hF);
      if (wr)             r.rd = rd_model;
      else if (abort_exp) r.rd = '0;
      else if (nb == 4)   r.rd = rd;
      else                r.rd = rd & ((DW'(1) << (8 * nb)) - 1);
      rd_model = r.rd;
      r.req = req;
      resq.push_back(r);
      // drive command
      @(negedge clk);
      cmd_valid = 1'b1; cmd_bus = 2'(bus); cmd_write = wr;
      cmd_addr = addr; cmd_size_log2 = 3'(sz); cmd_wdata = wd;
      @(negedge clk);
      if (inject) begin
         check(busy == 1'b1, "R10 busy during cycle", {63'd0, busy}, 64'd1);
         cmd_bus = 2'd1; cmd_write = ~wr; cmd_addr = 32'h1234_5678;
      end else cmd_valid = 1'b0;
      while (lad_oe) @(negedge clk);
      cmd_valid = 1'b0;
      lad_in = 4'h3;             // released clock: must be ignored (R6)
      @(negedge clk);
      for (int i = 0; i < nsync; i++) begin
         lad_in = syncs[4*i +: 4];
         @(negedge clk);
      end
      if (!abort_exp) begin
         lad_in = 4'h0;
         @(negedge clk);
         if (!wr) for (int j = 0; j < 2 * nb; j++) begin
            lad_in = rd[4*j +: 4];
            @(negedge clk);
         end
         lad_in = tar0;
         @(negedge clk);
         lad_in = 4'hF;
         @(negedge clk);
      end
      lad_in = 4'hF;
      repeat (3) @(negedge clk);
      check(resq.size() == 0, {req, " R9 done arrived"}, 64'(resq.size()), 64'd0);
      check(nibq.size() == 0, {req, " R5 stream complete"}, 64'(nibq.size()), 64'd0);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000 && !finished) begin
         finished = 1'b1;
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R12 reset idle", {61'd0, busy, done, error}, 64'd0);
      check(lad_oe == 1'b0 && lframe_n == 1'b1, "R1 reset bus released", {62'd0, lad_oe, lframe_n}, 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      // bus, wr, addr, size, wdata, rdata, syncs, nsync, abort, tar0, inject
      run_cycle(0, 0, 32'h0ABC_DEF1, 0, '0, 32'h0000_005A, 32'h0, 0, 0, 4'hF, 0, "R8 fwh read");
      run_cycle(0, 1, 32'h0FF0_1234, 1, 32'h0000_BEEF, '0, 32'h55, 2, 0, 4'hF, 0, "R6 fwh write short waits");
      run_cycle(1, 0, 32'hFFC0_1234, 2, '0, 32'hCAFE_F00D, 32'h6, 1, 0, 4'hF, 0, "R8 lpc read long wait");
      run_cycle(1, 1, 32'h8765_4321, 0, 32'h0000_00A5, '0, 32'h0, 0, 0, 4'hF, 0, "R8 lpc write keeps rdata");
      run_cycle(2, 0, 32'h1357_9BDF, 1, '0, 32'h0000_3C96, 32'h0, 0, 0, 4'hF, 0, "R2 isa read");
      run_cycle(2, 1, 32'h2468_ACE0, 2, 32'h0102_0304, '0, 32'h5, 1, 0, 4'hF, 0, "R2 isa write");
      run_cycle(1, 0, 32'h0000_0010, 3, '0, 32'h89AB_CDEF, 32'h0, 0, 0, 4'hF, 0, "R4 size clamp");
      run_cycle(0, 0, 32'h0000_0020, 1, '0, 32'h0000_1111, 32'h95, 2, 1, 4'hF, 0, "R7 bad sync");
      run_cycle(1, 0, 32'h0000_0030, 0, '0, 32'h0000_0077, 32'h0, 0, 0, 4'h7, 0, "R9 bad turnaround");
      run_cycle(1, 0, 32'h0000_0040, 0, '0, 32'h0000_0042, 32'h656, 3, 0, 4'hF, 0, "R11 within limit");
      run_cycle(0, 1, 32'h0000_0050, 0, 32'h0000_0011, '0, 32'h666, 3, 1, 4'hF, 0, "R11 limit exceeded");
      long_wait_limit = 16'd0;
      run_cycle(1, 0, 32'h0000_0060, 0, '0, 32'h0000_0033, 32'h6, 1, 1, 4'hF, 0, "R11 zero limit");
      long_wait_limit = 16'd2;
      run_cycle(1, 0, 32'h00C0_FFEE, 1, '0, 32'h0000_ABCD, 32'h0, 0, 0, 4'hF, 1, "R10 command while busy");
      repeat (4) @(negedge clk);
      check(busy == 1'b0, "R10 idle after run", {63'd0, busy}, 64'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule